// File: doc/BRIEF.md
# Configuration Access Router

This block takes CPU loads and stores that fall in a memory-mapped configuration window and turns them into configuration requests for a PCIe root port. The two space-select bits at the top of the window offset decide where an access goes. It can go to the root complex's own configuration space as a Type 0 request, or out to an external device as a Type 1 request. The bus, device and function fields of an outgoing Type 1 header do not come from the address. They come from a separate target-ID register that software writes through a small CSR port and may read back before it starts the access.

Some accesses never reach the port. Certain root-space accesses are screened out: those that name a nonzero device/function, and those that hit the two base address registers the root complex uses for its inbound mapping. A screened access completes at once with a not-found flag. A screened read returns all ones. A screened write is dropped. On the older IP revision, one bit of one root-space dword has to be patched in read data, and the block does that. Every forwarded read fetches a full aligned dword. The block then shifts and masks the result for byte and halfword accesses. Only one access is outstanding at a time, and the completion side is assumed to always answer.

Top module: `cfg_router`

## Requirements
- R1: Window offset bits [17:16] select the target. 2'b01 forwards a Type 1 request (cfg_type1=1). 2'b00 and 2'b10 forward a Type 0 request to the root complex's own space. 2'b11 is not forwarded and completes with rsp_not_found=1. cfg_dword carries offset bits [11:2].
- R2: The target-ID register holds bus in bits [15:8], device in bits [7:3] and function in bits [2:0]. It resets to zero, is loaded when id_wr_en is high at a clock edge, and shows its stored value on id_rd_data from the next cycle.
- R3: A forwarded Type 1 request carries the target-ID register value on cfg_id. A root-space request carries cfg_id equal to zero.
- R4: A root-space access is not forwarded and completes with rsp_not_found=1 while the target-ID register bits [7:0] (device/function) are nonzero.
- R5: Root-space reads and writes to the dwords at offsets 0x10 and 0x14 are not forwarded and complete with rsp_not_found=1. The same offsets in Type 1 space are forwarded.
- R6: With LEGACY_IP=1, a read of root-space dword 0x5C has bit 16 of the returned dword cleared before extraction. No other bit and no other dword or space is altered.
- R7: Forwarded reads use cfg_be=4'hF. rsp_rdata equals (dword >> 8*offset[1:0]) masked to the access size. Size codes: 0 is byte (mask 0xFF), 1 is halfword (mask 0xFFFF), 2 and 3 are word.
- R8: Forwarded writes pass req_wdata unchanged on cfg_wdata. cfg_be is 4'b0001<<offset[1:0] for a byte, 4'b0011<<offset[1:0] truncated to 4 bits for a halfword, and 4'hF for a word.
- R9: A screened read returns all ones after extraction (0xFF, 0xFFFF or 0xFFFFFFFF) with rsp_not_found=1. A screened write issues nothing and returns rsp_rdata=0 with rsp_not_found=1.
- R10: Timing. A screened access has a one-cycle rsp_valid pulse in the cycle after acceptance. A forwarded access has a one-cycle cfg_valid pulse in the cycle after acceptance, and a one-cycle rsp_valid pulse (rsp_not_found=0) in the cycle after cpl_valid is sampled. A completed write returns rsp_rdata=0.
- R11: A req_valid while a forwarded access awaits its completion is ignored. A cpl_valid while no access is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_wr_en | input | 1 | Load the target-ID register |
| id_wr_data | input | 16 | New target-ID value |
| id_rd_data | output | 16 | Stored target-ID value |
| req_valid | input | 1 | Window access presented (accepted when idle) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 18 | Offset within the configuration window |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Lane-aligned store data |
| rsp_valid | output | 1 | Access complete, one-cycle pulse |
| rsp_rdata | output | 32 | Right-justified load data |
| rsp_not_found | output | 1 | Access was screened |
| cfg_valid | output | 1 | Request issue pulse to the root port |
| cfg_type1 | output | 1 | 1 = Type 1, 0 = Type 0 |
| cfg_write | output | 1 | Request is a write |
| cfg_id | output | 16 | Bus/device/function of the target |
| cfg_dword | output | 10 | Dword index within the function's space |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cpl_valid | input | 1 | Completion from the root port |
| cpl_rdata | input | 32 | Completion dword |

## Verification
A screened access answers in the cycle after the access is accepted. A forwarded access raises its issue pulse in that same cycle. Its response appears one cycle after the bench raises its completion. The bench's responder raises the completion two cycles after it sees the issue pulse, so a forwarded response is due four sample points after the request is driven and a screened one at the first. At every sample point in between, the bench checks that neither pulse is present. It also checks the cycle after each response, so that a lost, early, late or doubled pulse is reported.

// File: rtl/cfg_router_pkg.sv
// Shared types and helpers for the configuration access router.
// Assumes a 32-bit configuration dword and 4 byte lanes.
package cfg_router_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rt_state_e;

    // Mask that keeps the low bytes covered by an access size.
    function automatic logic [31:0] size_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_id_reg.sv
// Target-ID register: holds bus/device/function for outgoing requests.
// Assumes software loads it before starting an access; reads back directly.
module cfg_id_reg #(
    parameter int ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_data,
    output logic [ID_W-1:0] q
);

    // Load on write strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

endmodule

// File: rtl/cfg_decode.sv
// Address decode and screening for one window access.
// Assumes the two space-select bits sit at the top of the window offset
// and that the device/function field is the low DF_W bits of the ID.
module cfg_decode
    import cfg_router_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int REG_W     = 10,
    parameter int DF_W      = 8,
    parameter bit LEGACY_IP = 1'b1,
    parameter int PATCH_DW  = 23,
    parameter int BAR0_DW   = 4,
    parameter int BAR1_DW   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  acc_size_e         size,
    input  logic [DF_W-1:0]   devfn,
    output logic              type1,
    output logic              suppress,
    output logic              patch,
    output logic [3:0]        be,
    output logic [REG_W-1:0]  dword
);

    logic [1:0] space;
    logic       root;
    logic       unmapped;
    logic       bar_hit;
    logic       unused_addr_bits;

    assign space            = addr[ADDR_W-1:ADDR_W-2];
    assign dword            = addr[REG_W+1:2];
    assign unused_addr_bits = ^addr[ADDR_W-3:REG_W+2];

    // Space selection: bit 16 clear is root, 2'b01 is external, 2'b11 is a hole.
    always_comb begin
        root     = ~space[0];
        type1    = (space == 2'b01);
        unmapped = (space == 2'b11);
    end

    // Screening of root-space accesses.
    always_comb begin
        bar_hit  = (dword == REG_W'(BAR0_DW)) || (dword == REG_W'(BAR1_DW));
        suppress = unmapped || (root && ((devfn != '0) || bar_hit));
        patch    = LEGACY_IP && root && !write && (dword == REG_W'(PATCH_DW));
    end

    // Byte enables: reads fetch the full dword, writes cover their lanes.
    always_comb begin
        if (!write) be = 4'hF;
        else begin
            case (size)
                SZ_BYTE: be = 4'b0001 << addr[1:0];
                SZ_HALF: be = 4'b0011 << addr[1:0];
                default: be = 4'hF;
            endcase
        end
    end

endmodule

// File: rtl/cfg_read_align.sv
// Read-data path: optional capability-bit patch, lane shift, size mask.
// Assumes the raw dword is naturally aligned; the patch exists only for the
// legacy revision and is generated away otherwise.
module cfg_read_align
    import cfg_router_pkg::*;
#(
    parameter bit LEGACY_IP = 1'b1,
    parameter int PATCH_BIT = 16
) (
    input  logic [31:0] raw,
    input  logic        patch,
    input  logic [1:0]  lane,
    input  acc_size_e   size,
    output logic [31:0] data
);

    logic [31:0] fixed;

    generate
        if (LEGACY_IP) begin : g_patch
            // Clear the capability bit on the patched dword.
            always_comb begin
                fixed = raw;
                if (patch) fixed[PATCH_BIT] = 1'b0;
            end
        end else begin : g_nopatch
            logic unused_patch;
            assign unused_patch = patch;
            assign fixed        = raw;
        end
    endgenerate

    // Right-justify the addressed lanes and keep the access width.
    always_comb data = (fixed >> {lane, 3'b000}) & size_mask(size);

endmodule

// File: rtl/cfg_router.sv
// Configuration access router top: accepts one window access at a time,
// screens it, issues a single-cycle request and returns shaped read data.
// Assumes the root port always answers a request with one cpl_valid pulse.
module cfg_router
    import cfg_router_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int REG_W        = 10,
    parameter int ID_W         = 16,
    parameter bit LEGACY_IP    = 1'b1,
    parameter int CAP_BASE     = 'h40,
    parameter int ROOT_CTL_OFS = 'h1C,
    parameter int PATCH_BIT    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_wr_en,
    input  logic [ID_W-1:0]   id_wr_data,
    output logic [ID_W-1:0]   id_rd_data,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_not_found,
    output logic              cfg_valid,
    output logic              cfg_type1,
    output logic              cfg_write,
    output logic [ID_W-1:0]   cfg_id,
    output logic [REG_W-1:0]  cfg_dword,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cpl_valid,
    input  logic [31:0]       cpl_rdata
);

    localparam int DF_W     = 8;
    localparam int PATCH_DW = (CAP_BASE + ROOT_CTL_OFS) / 4;
    localparam int BAR0_DW  = 'h10 / 4;
    localparam int BAR1_DW  = 'h14 / 4;

    rt_state_e        state;
    acc_size_e        size_in;
    acc_size_e        size_q;
    acc_size_e        size_sel;
    logic [1:0]       lane_q;
    logic [1:0]       lane_sel;
    logic             patch_q;
    logic             patch_sel;
    logic [31:0]      raw_sel;
    logic [31:0]      shaped;
    logic             dec_type1;
    logic             dec_suppress;
    logic             dec_patch;
    logic [3:0]       dec_be;
    logic [REG_W-1:0] dec_dword;

    assign size_in = acc_size_e'(req_size);

    cfg_id_reg #(.ID_W(ID_W)) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (id_wr_en),
        .wr_data (id_wr_data),
        .q       (id_rd_data)
    );

    cfg_decode #(
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .DF_W      (DF_W),
        .LEGACY_IP (LEGACY_IP),
        .PATCH_DW  (PATCH_DW),
        .BAR0_DW   (BAR0_DW),
        .BAR1_DW   (BAR1_DW)
    ) u_dec (
        .addr     (req_addr),
        .write    (req_write),
        .size     (size_in),
        .devfn    (id_rd_data[DF_W-1:0]),
        .type1    (dec_type1),
        .suppress (dec_suppress),
        .patch    (dec_patch),
        .be       (dec_be),
        .dword    (dec_dword)
    );

    // Shared shaping path: all ones for a screened read, else the completion.
    always_comb begin
        if (state == ST_IDLE) begin
            raw_sel   = 32'hFFFF_FFFF;
            patch_sel = 1'b0;
            lane_sel  = req_addr[1:0];
            size_sel  = size_in;
        end else begin
            raw_sel   = cpl_rdata;
            patch_sel = patch_q;
            lane_sel  = lane_q;
            size_sel  = size_q;
        end
    end

    cfg_read_align #(
        .LEGACY_IP (LEGACY_IP),
        .PATCH_BIT (PATCH_BIT)
    ) u_align (
        .raw   (raw_sel),
        .patch (patch_sel),
        .lane  (lane_sel),
        .size  (size_sel),
        .data  (shaped)
    );

    // Access sequencer: accept, screen or issue, then wait for completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cfg_valid     <= 1'b0;
            cfg_type1     <= 1'b0;
            cfg_write     <= 1'b0;
            cfg_id        <= '0;
            cfg_dword     <= '0;
            cfg_be        <= '0;
            cfg_wdata     <= '0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            rsp_not_found <= 1'b0;
            lane_q        <= '0;
            size_q        <= SZ_BYTE;
            patch_q       <= 1'b0;
        end else begin
            cfg_valid <= 1'b0;
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (dec_suppress) begin
                            rsp_valid     <= 1'b1;
                            rsp_not_found <= 1'b1;
                            rsp_rdata     <= req_write ? 32'h0 : shaped;
                        end else begin
                            cfg_valid <= 1'b1;
                            cfg_type1 <= dec_type1;
                            cfg_write <= req_write;
                            cfg_id    <= dec_type1 ? id_rd_data : '0;
                            cfg_dword <= dec_dword;
                            cfg_be    <= dec_be;
                            cfg_wdata <= req_wdata;
                            lane_q    <= req_addr[1:0];
                            size_q    <= size_in;
                            patch_q   <= dec_patch;
                            state     <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cpl_valid) begin
                        rsp_valid     <= 1'b1;
                        rsp_not_found <= 1'b0;
                        rsp_rdata     <= cfg_write ? 32'h0 : shaped;
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_router_chk.sv
// Protocol checker for cfg_router, attached with bind below.
// Assumes the BAR dword indices and the reset polarity of the top module.
module cfg_router_chk #(
    parameter int ID_W  = 16,
    parameter int REG_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_wr_en,
    input logic [ID_W-1:0]  id_wr_data,
    input logic [ID_W-1:0]  id_rd_data,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_not_found,
    input logic             cfg_valid,
    input logic             cfg_type1,
    input logic             cfg_write,
    input logic [ID_W-1:0]  cfg_id,
    input logic [REG_W-1:0] cfg_dword,
    input logic [3:0]       cfg_be
);

    // R2
    id_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(id_wr_en) |-> id_rd_data == $past(id_wr_data));

    // R3
    root_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_type1 |-> cfg_id == '0);

    // R5
    bar_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_type1 |-> (cfg_dword != REG_W'(4)) && (cfg_dword != REG_W'(5)));

    // R7
    read_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_write |-> cfg_be == 4'hF);

    // R8
    write_be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && cfg_write |-> cfg_be != 4'h0);

    // R9
    screened_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_not_found |-> !$past(cfg_valid));

    // R10
    issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);

    // R10
    issue_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(req_valid));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !rsp_valid);

endmodule

bind cfg_router cfg_router_chk #(.ID_W(ID_W), .REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_wr_en      (id_wr_en),
    .id_wr_data    (id_wr_data),
    .id_rd_data    (id_rd_data),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_not_found (rsp_not_found),
    .cfg_valid     (cfg_valid),
    .cfg_type1     (cfg_type1),
    .cfg_write     (cfg_write),
    .cfg_id        (cfg_id),
    .cfg_dword     (cfg_dword),
    .cfg_be        (cfg_be)
);

// File: tb/tb_cfg_router.sv
// Bench for cfg_router: behavioural reference model checked at every
// sample point of each access, with a bench-side completion responder.
module tb_cfg_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_wr_en = 1'b0;
    logic [15:0] id_wr_data = '0;
    logic [15:0] id_rd_data;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_not_found;
    logic        cfg_valid;
    logic        cfg_type1;
    logic        cfg_write;
    logic [15:0] cfg_id;
    logic [9:0]  cfg_dword;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cpl_valid = 1'b0;
    logic [31:0] cpl_rdata = '0;

    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] id_shadow = '0;

    always #5 clk = ~clk;

    cfg_router dut (
        .clk(clk), .rst_n(rst_n),
        .id_wr_en(id_wr_en), .id_wr_data(id_wr_data), .id_rd_data(id_rd_data),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_not_found(rsp_not_found),
        .cfg_valid(cfg_valid), .cfg_type1(cfg_type1), .cfg_write(cfg_write),
        .cfg_id(cfg_id), .cfg_dword(cfg_dword), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Completion data the modelled device returns for a request.
    function automatic logic [31:0] dev_data(bit t1, logic [15:0] id, logic [9:0] dw);
        if (t1) return {id, 6'd0, dw};
        return 32'hDEAD_0000 | {22'd0, dw};
    endfunction

    function automatic logic [31:0] size_mask(logic [1:0] sz);
        if (sz == 2'd0) return 32'hFF;
        if (sz == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] shape(logic [31:0] raw, logic [1:0] a, logic [1:0] sz);
        return (raw >> (8 * a)) & size_mask(sz);
    endfunction

    function automatic logic [3:0] exp_be(bit wr, logic [1:0] a, logic [1:0] sz);
        logic [7:0] wide;
        if (!wr || sz >= 2'd2) return 4'hF;
        wide = (sz == 2'd0) ? (8'h01 << a) : (8'h03 << a);
        return wide[3:0];
    endfunction

    task automatic set_id(input logic [15:0] v);
        @(negedge clk);
        id_wr_en = 1'b1; id_wr_data = v;
        @(negedge clk);
        id_wr_en = 1'b0;
        id_shadow = v;
        chk(id_rd_data == v, "R2", "id readback", {16'd0, id_rd_data}, {16'd0, v});
    endtask

    // One access; fwd says whether the model expects it forwarded.
    task automatic access(input logic [17:0] a, input bit wr, input logic [1:0] sz,
                          input logic [31:0] wd, input bit fwd, input string rq,
                          input bit poke);
        bit          t1;
        logic [15:0] eid;
        logic [31:0] raw;
        logic [31:0] exp_rd;
        t1  = (a[17:16] == 2'b01);
        eid = t1 ? id_shadow : 16'h0;
        raw = dev_data(t1, eid, a[11:2]);
        if (!t1 && a[11:2] == 10'h17) raw[16] = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (fwd) begin
            chk(cfg_valid == 1'b1, rq, "issue pulse (R10)", {31'd0, cfg_valid}, 1);
            chk(rsp_valid == 1'b0, rq, "no early rsp (R10)", {31'd0, rsp_valid}, 0);
            chk(cfg_type1 == t1, rq, "request type (R1)", {31'd0, cfg_type1}, {31'd0, t1});
            chk(cfg_id == eid, rq, "target id (R3)", {16'd0, cfg_id}, {16'd0, eid});
            chk(cfg_dword == a[11:2], rq, "dword (R1)", {22'd0, cfg_dword}, {22'd0, a[11:2]});
            chk(cfg_write == wr, rq, "direction", {31'd0, cfg_write}, {31'd0, wr});
            chk(cfg_be == exp_be(wr, a[1:0], sz), rq, "byte enables (R7/R8)",
                {28'd0, cfg_be}, {28'd0, exp_be(wr, a[1:0], sz)});
            if (wr) chk(cfg_wdata == wd, rq, "write data (R8)", cfg_wdata, wd);
            @(negedge clk);
            if (poke) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h0; req_size = 2'd2;
            end
            chk(rsp_valid == 1'b0 && cfg_valid == 1'b0, rq, "idle while waiting (R10)",
                {30'd0, rsp_valid, cfg_valid}, 0);
            @(negedge clk);
            req_valid = 1'b0;
            chk(cfg_valid == 1'b0 && rsp_valid == 1'b0, rq, "no second issue (R11)",
                {30'd0, rsp_valid, cfg_valid}, 0);
            cpl_valid = 1'b1; cpl_rdata = dev_data(t1, eid, a[11:2]);
            @(negedge clk);
            cpl_valid = 1'b0;
            exp_rd = wr ? 32'h0 : shape(raw, a[1:0], sz);
            chk(rsp_valid == 1'b1, rq, "rsp after completion (R10)", {31'd0, rsp_valid}, 1);
            chk(rsp_not_found == 1'b0, rq, "found flag", {31'd0, rsp_not_found}, 0);
            chk(rsp_rdata == exp_rd, rq, "read data", rsp_rdata, exp_rd);
        end else begin
            exp_rd = wr ? 32'h0 : size_mask(sz);
            chk(cfg_valid == 1'b0, rq, "not issued (R9)", {31'd0, cfg_valid}, 0);
            chk(rsp_valid == 1'b1, rq, "immediate rsp (R10)", {31'd0, rsp_valid}, 1);
            chk(rsp_not_found == 1'b1, rq, "not-found flag (R9)", {31'd0, rsp_not_found}, 1);
            chk(rsp_rdata == exp_rd, rq, "screened data (R9)", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0 && cfg_valid == 1'b0, rq, "single pulse (R10/R11)",
            {30'd0, rsp_valid, cfg_valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(id_rd_data == 16'h0, "R2", "reset id", {16'd0, id_rd_data}, 0);
        chk(rsp_valid == 1'b0 && cfg_valid == 1'b0, "R10", "reset outputs",
            {30'd0, rsp_valid, cfg_valid}, 0);

        // R1 R3 R7: root space reads with several shapes
        access(18'h00000, 1'b0, 2'd2, 32'h0, 1'b1, "R1", 1'b0);
        access(18'h00002, 1'b0, 2'd0, 32'h0, 1'b1, "R7", 1'b0);
        access(18'h00006, 1'b0, 2'd1, 32'h0, 1'b1, "R7", 1'b0);
        access(18'h00003, 1'b0, 2'd3, 32'h0, 1'b1, "R7", 1'b0);
        access(18'h20008, 1'b0, 2'd2, 32'h0, 1'b1, "R1", 1'b0);
        // R6: patched capability dword, word and upper halfword
        access(18'h0005C, 1'b0, 2'd2, 32'h0, 1'b1, "R6", 1'b0);
        access(18'h0005E, 1'b0, 2'd1, 32'h0, 1'b1, "R6", 1'b0);
        // R5 R9: hidden BARs
        access(18'h00010, 1'b0, 2'd2, 32'h0, 1'b0, "R5", 1'b0);
        access(18'h00011, 1'b0, 2'd0, 32'h0, 1'b0, "R9", 1'b0);
        access(18'h00016, 1'b0, 2'd1, 32'h0, 1'b0, "R9", 1'b0);
        access(18'h00014, 1'b1, 2'd2, 32'h1234_5678, 1'b0, "R5", 1'b0);
        // R1: unmapped space
        access(18'h30000, 1'b0, 2'd2, 32'h0, 1'b0, "R1", 1'b0);

        // R2 R3: external device bus 3 dev 5 fn 3
        set_id(16'h032B);
        access(18'h10000, 1'b0, 2'd2, 32'h0, 1'b1, "R3", 1'b0);
        access(18'h1005C, 1'b0, 2'd2, 32'h0, 1'b1, "R6", 1'b0);
        access(18'h10010, 1'b0, 2'd2, 32'h0, 1'b1, "R5", 1'b0);
        // R4: root access with nonzero device/function
        access(18'h00000, 1'b0, 2'd2, 32'h0, 1'b0, "R4", 1'b0);
        access(18'h00004, 1'b1, 2'd2, 32'h0000_0006, 1'b0, "R4", 1'b0);
        // R8: writes of each size
        access(18'h10003, 1'b1, 2'd0, 32'hAB00_0000, 1'b1, "R8", 1'b0);
        access(18'h10002, 1'b1, 2'd1, 32'hBEEF_0000, 1'b1, "R8", 1'b0);
        access(18'h10041, 1'b1, 2'd1, 32'h00CA_FE00, 1'b1, "R8", 1'b0);
        access(18'h10004, 1'b1, 2'd2, 32'h0000_0147, 1'b1, "R8", 1'b0);

        // R3: bus-only ID lets root accesses through with zero ID
        set_id(16'h0700);
        access(18'h00004, 1'b1, 2'd2, 32'h0000_0006, 1'b1, "R3", 1'b0);
        // R11: request during an outstanding access is ignored
        access(18'h10008, 1'b0, 2'd2, 32'h0, 1'b1, "R11", 1'b1);
        // R11: completion while idle is ignored
        @(negedge clk);
        cpl_valid = 1'b1; cpl_rdata = 32'h5555_5555;
        @(negedge clk);
        cpl_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R11", "stray completion", {31'd0, rsp_valid}, 0);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && cfg_valid == 1'b0, "R11", "still idle",
            {30'd0, rsp_valid, cfg_valid}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule